// File: doc/BRIEF.md
# Serial Write-Only Configuration Register Bank

This block is a two-wire serial slave that only receives. A controller on the bus sends a device address with the write bit, then a register index (the subaddress), then one or more data bytes. The block stores them in fifteen registers. Indices 00H to 0BH are twelve 6-bit alignment values and indices 0CH to 0EH are three 8-bit control bytes. All registers are presented in parallel on the outputs so that the surrounding video logic can use them directly. The block acknowledges a byte by pulling the data line low through an open-drain enable output.

Two write modes exist, chosen by bit 5 of register 0CH. In direct mode a data byte takes effect as soon as it is received, and the index steps forward after each byte. Stepping past 0EH lands on the unused index 0FH. That byte is acknowledged and discarded, and the index then wraps to 00H. In buffered mode a single data byte is parked in a holding latch and copied into its register at the next vertical blanking interval. While a byte is parked the device refuses every new transfer, so frame-synchronous updates never tear.

Top module: `i2c_cfg_bank`

## Requirements
- R1: After reset, every alignment register (indices 00H..0BH) reads 01H and every control register (0CH..0EH) reads 00H.
- R2: The device responds only to the address byte 88H, which is the 7-bit address 1000100 followed by the write bit 0. Any other address byte, including the read form 89H, is not acknowledged, and the transfer that follows changes no register.
- R3: Each accepted byte is acknowledged by holding `sda_low_o` high from the SCL falling edge after its eighth bit until the next SCL falling edge. The output is never raised while SCL is high.
- R4: Indices 00H..0BH store data bits D5..D0 and drop D7 and D6. Indices 0CH..0EH store all eight bits. Alignment index k appears at `align_o[6k+5:6k]`, and control index 0CH+j appears at `ctl_o[8j+7:8j]`.
- R5: A subaddress byte greater than 0EH is not acknowledged, and nothing in that transfer is written. All eight bits are compared, so 8EH is refused.
- R6: In direct mode (0CH bit 5 = 0), each acknowledged data byte is written to the current index within a few clocks, and the index then increments for the next byte of the same transfer.
- R7: In direct mode, a data byte that falls on index 0FH is acknowledged and writes nothing, and the next byte goes to index 00H.
- R8: In buffered mode (0CH bit 5 = 1), the first data byte of a transfer is acknowledged and held. A second data byte in the same transfer is not acknowledged. The held byte reaches its register on the first clock with `vblank_i` high, and not before.
- R9: While a held byte waits for `vblank_i`, the address byte of any new transfer is not acknowledged.
- R10: A START or STOP condition in the middle of a byte abandons the transfer without writing a partial byte. A repeated START begins a new transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line level, asynchronous |
| sda_low_o | output | 1 | Open-drain enable: 1 pulls the data line low (acknowledge) |
| vblank_i | input | 1 | Vertical blanking level, synchronous to clk |
| align_o | output | 72 | Twelve 6-bit alignment registers, index k at bits 6k+5..6k |
| ctl_o | output | 24 | Three 8-bit control registers, index 0CH+j at bits 8j+7..8j |

## Verification
On every cycle the assertions check four things. An acknowledge only begins while SCL is low. No acknowledge begins while a held byte is outstanding. A held byte is released only in a cycle that follows `vblank_i` high. The register outputs move only after an internal write strobe, and they come out of reset at their reset values. Other behaviour is visible only in the bench's scenarios: address and subaddress decoding, dropping of the upper data bits, the increment sequence through the 0FH wrap, refusal of a second byte in buffered mode, and abandonment of a byte cut short by STOP or repeated START.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
  localparam int          ALIGN_W     = 6;
  localparam int          NUM_ALIGN   = 12;
  localparam int          NUM_CTL     = 3;
  localparam int          SUB_W       = 4;
  localparam int          BYTE_W      = 8;
  localparam int          BUF_EN_BIT  = 5;
  localparam logic [6:0]  DEV_ADDR    = 7'h44;
  localparam logic [3:0]  SUB_LAST    = 4'hE;
  localparam logic [3:0]  SUB_WRAP    = 4'hF;
  localparam logic [5:0]  ALIGN_RST   = 6'h01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK_ADDR,
    ST_SUB,
    ST_ACK_SUB,
    ST_DATA,
    ST_ACK_DATA,
    ST_WAIT
  } rx_state_t;
endpackage

// File: rtl/i2c_line_cond.sv
module i2c_line_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_lvl_o  = scl_q[STAGES-1];
  assign sda_lvl_o  = sda_q[STAGES-1];
  assign scl_rise_o = scl_lvl_o & ~scl_d;
  assign scl_fall_o = ~scl_lvl_o & scl_d;
  assign start_o    = scl_lvl_o & scl_d & sda_d & ~sda_lvl_o;
  assign stop_o     = scl_lvl_o & scl_d & ~sda_d & sda_lvl_o;
endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
  import i2c_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_lvl_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              pending_i,
  input  logic              bufmode_i,
  output logic              ack_o,
  output logic              req_o,
  output logic              req_buf_o,
  output logic [SUB_W-1:0]  req_sub_o,
  output logic [BYTE_W-1:0] req_data_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  rx_state_t          st;
  logic [BYTE_W-1:0]  sh;
  logic [CNT_W-1:0]   cnt;
  logic [SUB_W-1:0]   ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      sh         <= '0;
      cnt        <= '0;
      ptr        <= '0;
      ack_o      <= 1'b0;
      req_o      <= 1'b0;
      req_buf_o  <= 1'b0;
      req_sub_o  <= '0;
      req_data_o <= '0;
    end else begin
      req_o <= 1'b0;
      if (start_i) begin
        st    <= ST_ADDR;
        cnt   <= '0;
        ack_o <= 1'b0;
      end else if (stop_i) begin
        st    <= ST_IDLE;
        cnt   <= '0;
        ack_o <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_SUB, ST_DATA: begin
            if (scl_rise_i && cnt != FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_lvl_i};
              cnt <= cnt + 1'b1;
            end else if (scl_fall_i && cnt == FULL) begin
              cnt <= '0;
              st  <= ST_WAIT;
              if (st == ST_ADDR) begin
                if (sh == {DEV_ADDR, 1'b0} && !pending_i) begin
                  ack_o <= 1'b1;
                  st    <= ST_ACK_ADDR;
                end
              end else if (st == ST_SUB) begin
                if (sh <= {{(BYTE_W-SUB_W){1'b0}}, SUB_LAST}) begin
                  ptr   <= sh[SUB_W-1:0];
                  ack_o <= 1'b1;
                  st    <= ST_ACK_SUB;
                end
              end else if (bufmode_i) begin
                if (!pending_i) begin
                  req_o      <= 1'b1;
                  req_buf_o  <= 1'b1;
                  req_sub_o  <= ptr;
                  req_data_o <= sh;
                  ack_o      <= 1'b1;
                  st         <= ST_ACK_DATA;
                end
              end else begin
                req_o      <= (ptr != SUB_WRAP);
                req_buf_o  <= 1'b0;
                req_sub_o  <= ptr;
                req_data_o <= sh;
                ptr        <= ptr + 1'b1;
                ack_o      <= 1'b1;
                st         <= ST_ACK_DATA;
              end
            end
          end
          ST_ACK_ADDR: if (scl_fall_i) begin ack_o <= 1'b0; st <= ST_SUB;  end
          ST_ACK_SUB:  if (scl_fall_i) begin ack_o <= 1'b0; st <= ST_DATA; end
          ST_ACK_DATA: if (scl_fall_i) begin ack_o <= 1'b0; st <= ST_DATA; end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_wr_stage.sv
module i2c_wr_stage
  import i2c_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              req_buf_i,
  input  logic [SUB_W-1:0]  req_sub_i,
  input  logic [BYTE_W-1:0] req_data_i,
  input  logic              vblank_i,
  output logic              pending_o,
  output logic              wr_en_o,
  output logic [SUB_W-1:0]  wr_sub_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  logic [SUB_W-1:0]  hold_sub;
  logic [BYTE_W-1:0] hold_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_o <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_sub_o  <= '0;
      wr_data_o <= '0;
      hold_sub  <= '0;
      hold_data <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (req_i && !req_buf_i) begin
        wr_en_o   <= 1'b1;
        wr_sub_o  <= req_sub_i;
        wr_data_o <= req_data_i;
      end else if (req_i) begin
        hold_sub  <= req_sub_i;
        hold_data <= req_data_i;
        pending_o <= 1'b1;
      end else if (pending_o && vblank_i) begin
        wr_en_o   <= 1'b1;
        wr_sub_o  <= hold_sub;
        wr_data_o <= hold_data;
        pending_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import i2c_cfg_pkg::*;
#(
  parameter int N_ALIGN = NUM_ALIGN,
  parameter int A_W     = ALIGN_W,
  parameter int N_CTL   = NUM_CTL
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en_i,
  input  logic [SUB_W-1:0]       wr_sub_i,
  input  logic [BYTE_W-1:0]      wr_data_i,
  output logic [N_ALIGN*A_W-1:0] align_o,
  output logic [N_CTL*BYTE_W-1:0] ctl_o
);
  for (genvar i = 0; i < N_ALIGN; i++) begin : g_align
    always_ff @(posedge clk) begin
      if (rst)
        align_o[i*A_W +: A_W] <= A_W'(ALIGN_RST);
      else if (wr_en_i && wr_sub_i == SUB_W'(i))
        align_o[i*A_W +: A_W] <= wr_data_i[A_W-1:0];
    end
  end

  for (genvar j = 0; j < N_CTL; j++) begin : g_ctl
    always_ff @(posedge clk) begin
      if (rst)
        ctl_o[j*BYTE_W +: BYTE_W] <= '0;
      else if (wr_en_i && wr_sub_i == SUB_W'(N_ALIGN + j))
        ctl_o[j*BYTE_W +: BYTE_W] <= wr_data_i;
    end
  end
endmodule

// File: rtl/i2c_cfg_bank.sv
module i2c_cfg_bank
  import i2c_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int N_ALIGN     = NUM_ALIGN,
  parameter int A_W         = ALIGN_W,
  parameter int N_CTL       = NUM_CTL
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_low_o,
  input  logic                    vblank_i,
  output logic [N_ALIGN*A_W-1:0]  align_o,
  output logic [N_CTL*BYTE_W-1:0] ctl_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic pending, req, req_buf, wr_en;
  logic [SUB_W-1:0]  req_sub, wr_sub;
  logic [BYTE_W-1:0] req_data, wr_data;

  i2c_line_cond #(.STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl_o(scl_lvl), .sda_lvl_o(sda_lvl),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_wr_fsm u_fsm (
    .clk(clk), .rst(rst), .sda_lvl_i(sda_lvl),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .pending_i(pending), .bufmode_i(ctl_o[BUF_EN_BIT]),
    .ack_o(sda_low_o), .req_o(req), .req_buf_o(req_buf),
    .req_sub_o(req_sub), .req_data_o(req_data)
  );

  i2c_wr_stage u_stage (
    .clk(clk), .rst(rst), .req_i(req), .req_buf_i(req_buf),
    .req_sub_i(req_sub), .req_data_i(req_data), .vblank_i(vblank_i),
    .pending_o(pending), .wr_en_o(wr_en), .wr_sub_o(wr_sub), .wr_data_o(wr_data)
  );

  cfg_reg_bank #(.N_ALIGN(N_ALIGN), .A_W(A_W), .N_CTL(N_CTL)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_sub_i(wr_sub),
    .wr_data_i(wr_data), .align_o(align_o), .ctl_o(ctl_o)
  );
endmodule

// File: rtl/i2c_cfg_chk.sv
module i2c_cfg_chk
  import i2c_cfg_pkg::*;
(
  input logic                         clk,
  input logic                         rst,
  input logic                         scl_lvl,
  input logic                         sda_low,
  input logic                         pending,
  input logic                         vblank,
  input logic                         wr_en,
  input logic [NUM_ALIGN*ALIGN_W-1:0] align,
  input logic [NUM_CTL*BYTE_W-1:0]    ctl
);
  a_r1_reset_values: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (align == {NUM_ALIGN{ALIGN_RST}}) && (ctl == '0));

  a_r3_ack_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low) |-> !scl_lvl);

  a_r9_no_ack_while_held: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_low) |-> !$past(pending));

  a_r8_release_in_vblank: assert property (@(posedge clk) disable iff (rst)
    $fell(pending) |-> $past(vblank));

  a_r8_held_copied: assert property (@(posedge clk) disable iff (rst)
    (pending && vblank) |=> !pending);

  a_r6_regs_move_on_write: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en) |-> ($stable(align) && $stable(ctl)));
endmodule

bind i2c_cfg_bank i2c_cfg_chk u_chk (
  .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .sda_low(sda_low_o),
  .pending(pending), .vblank(vblank_i), .wr_en(wr_en),
  .align(align_o), .ctl(ctl_o)
);

// File: tb/test_i2c_cfg_bank.sv
module test_i2c_cfg_bank;
  localparam int T = 10;
  localparam int NV = 6;
  // {subaddress, data byte, expected register value}
  localparam logic [23:0] VEC [NV] = '{
    {8'h00, 8'h3F, 8'h3F},
    {8'h04, 8'hC5, 8'h05},
    {8'h0B, 8'h80, 8'h00},
    {8'h0C, 8'h9F, 8'h9F},
    {8'h0D, 8'hFF, 8'hFF},
    {8'h0E, 8'hA5, 8'hA5}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1, vblank = 1'b0;
  logic sda_low;
  logic [71:0] align;
  logic [23:0] ctl;
  logic sda_bus;
  int nchk = 0, nerr = 0;
  bit done = 0;

  assign sda_bus = sda_m & ~sda_low;

  i2c_cfg_bank i_i2c_cfg_bank (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_low_o(sda_low), .vblank_i(vblank), .align_o(align), .ctl_o(ctl)
  );

  always #2.5 clk = ~clk;

  task automatic hw(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rv(int idx);
    if (idx < 12) return {2'b00, align[idx*6 +: 6]};
    return ctl[(idx-12)*8 +: 8];
  endfunction

  task automatic i2c_start();
    sda_m = 1'b1; hw(T);
    scl_m = 1'b1; hw(T);
    sda_m = 1'b0; hw(T);
    scl_m = 1'b0; hw(T);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; hw(T);
    scl_m = 1'b1; hw(T);
    sda_m = 1'b1; hw(T);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; hw(T);
      scl_m = 1'b1; hw(T);
      scl_m = 1'b0; hw(T);
    end
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; hw(T);
    scl_m = 1'b1; hw(T/2);
    ack = sda_low;
    hw(T/2);
    scl_m = 1'b0; hw(T);
  endtask

  task automatic write1(logic [7:0] adr, logic [7:0] sub, logic [7:0] dat,
                        output logic a0, output logic a1, output logic a2);
    i2c_start();
    send_byte(adr, a0);
    send_byte(sub, a1);
    send_byte(dat, a2);
    i2c_stop();
    hw(4);
  endtask

  task automatic vb_pulse();
    vblank = 1'b1; hw(1);
    vblank = 1'b0; hw(3);
  endtask

  initial begin
    logic a0, a1, a2, a3, a4, a5, a6;
    hw(5);
    rst = 1'b0;
    hw(3);

    // R1: reset values
    for (int k = 0; k < 15; k++)
      chk($sformatf("R1 reset idx %0d", k), rv(k), (k < 12) ? 8'h01 : 8'h00);

    // R4/R6: vector table of single direct writes
    for (int v = 0; v < NV; v++) begin
      write1(8'h88, VEC[v][23:16], VEC[v][15:8], a0, a1, a2);
      chk($sformatf("R3 acks vec %0d", v), {a0, a1, a2}, 3'b111);
      chk($sformatf("R4 value vec %0d", v), rv(int'(VEC[v][23:16])), VEC[v][7:0]);
    end

    // R2: wrong address and read form refused
    write1(8'h8A, 8'h00, 8'h11, a0, a1, a2);
    chk("R2 bad addr ack", {a0, a1, a2}, 3'b000);
    write1(8'h89, 8'h00, 8'h11, a0, a1, a2);
    chk("R2 read addr ack", a0, 1'b0);
    chk("R2 reg untouched", rv(0), 8'h3F);

    // R5: out-of-range subaddresses
    write1(8'h88, 8'h0F, 8'h07, a0, a1, a2);
    chk("R5 sub 0F ack", {a0, a1, a2}, 3'b100);
    write1(8'h88, 8'h10, 8'h07, a0, a1, a2);
    chk("R5 sub 10 ack", {a0, a1, a2}, 3'b100);
    write1(8'h88, 8'h8E, 8'h07, a0, a1, a2);
    chk("R5 sub 8E ack", {a0, a1, a2}, 3'b100);
    chk("R5 reg 0E untouched", rv(14), 8'hA5);
    chk("R5 reg 00 untouched", rv(0), 8'h3F);

    // R6/R7: auto-increment through the 0F wrap
    i2c_start();
    send_byte(8'h88, a0);
    send_byte(8'h0D, a1);
    send_byte(8'h11, a2);
    send_byte(8'h22, a3);
    send_byte(8'h33, a4);
    send_byte(8'h2A, a5);
    send_byte(8'h15, a6);
    i2c_stop();
    hw(4);
    chk("R6 burst acks", {a0, a1, a2, a3, a4, a5, a6}, 7'h7F);
    chk("R6 reg 0D", rv(13), 8'h11);
    chk("R6 reg 0E", rv(14), 8'h22);
    chk("R7 wrap reg 00", rv(0), 8'h2A);
    chk("R7 wrap reg 01", rv(1), 8'h15);
    chk("R7 reg 02 untouched", rv(2), 8'h01);

    // R10: STOP mid-byte
    i2c_start();
    send_byte(8'h88, a0);
    send_byte(8'h03, a1);
    send_bits(8'hFF, 4);
    i2c_stop();
    hw(4);
    chk("R10 stop abort reg 03", rv(3), 8'h01);

    // R10: repeated START mid-byte, then a fresh write
    i2c_start();
    send_byte(8'h88, a0);
    send_byte(8'h02, a1);
    send_bits(8'h3C, 5);
    i2c_start();
    send_byte(8'h88, a2);
    send_byte(8'h05, a3);
    send_byte(8'h09, a4);
    i2c_stop();
    hw(4);
    chk("R10 restart abort reg 02", rv(2), 8'h01);
    chk("R10 restart acks", {a2, a3, a4}, 3'b111);
    chk("R10 restart write reg 05", rv(5), 8'h09);

    // R8/R9: buffered mode
    write1(8'h88, 8'h0C, 8'h20, a0, a1, a2);
    chk("R8 enable buffered", rv(12), 8'h20);
    i2c_start();
    send_byte(8'h88, a0);
    send_byte(8'h06, a1);
    send_byte(8'h11, a2);
    send_byte(8'h22, a3);
    i2c_stop();
    hw(4);
    chk("R8 buffered acks", {a0, a1, a2, a3}, 4'b1110);
    chk("R8 held before vblank", rv(6), 8'h01);
    chk("R8 next reg untouched", rv(7), 8'h01);
    write1(8'h88, 8'h06, 8'h33, a0, a1, a2);
    chk("R9 addr refused while held", a0, 1'b0);
    chk("R9 reg still held", rv(6), 8'h01);
    vb_pulse();
    chk("R8 copied in vblank", rv(6), 8'h11);
    write1(8'h88, 8'h0C, 8'h00, a0, a1, a2);
    chk("R9 accepted after copy", {a0, a1, a2}, 3'b111);
    chk("R8 mode byte held", rv(12), 8'h20);
    vb_pulse();
    chk("R8 mode byte copied", rv(12), 8'h00);
    write1(8'h88, 8'h06, 8'h2B, a0, a1, a2);
    chk("R6 direct again", rv(6), 8'h2B);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule